// File: doc/BRIEF.md
# Receive Ring Burst Read Port

This block is the host-facing read side of a receive packet buffer ring. The ring itself is a synchronous RAM inside the block. A narrow fill port writes whole 32-bit words into it, and that port stands in for the receive logic that would normally fill the ring. The host loads a starting byte pointer and a byte count. A prefetch engine then reads the ring from that pointer into a small buffer. Each buffered entry is one host-width word: four bytes when the host is 32 bits wide, two bytes when it is 16 bits wide.

When four host-width words are waiting, the block raises a burst request. The host answers with an acknowledge strobe, and each acknowledged cycle hands over the next buffered word. The visible read pointer moves forward by one host width per beat and the remaining byte count moves down by the same amount. After the fourth beat the request drops. It comes back only when four more words are ready.

A mode input selects 16-bit or 32-bit host width. Any change of that input throws away the prefetched words. The block then fetches again from the current read pointer, so the host neither loses nor repeats data across the switch.

Top module: `rx_burst_port`

## Requirements
- R1: In 32-bit mode (mode16=0), bits [8k+7:8k] of a beat hold the ring byte at address read pointer + k, for k = 0..3. Ring word w holds byte address 4w+k in bits [8k+7:8k].
- R2: In 16-bit mode (mode16=1), a beat carries the byte at the read pointer in bits [7:0] and the next byte in bits [15:8]. Bits [31:16] are zero.
- R3: burst_req rises only when at least four host-width words are buffered and no burst is in progress. With fewer words buffered it stays low.
- R4: A cycle with burst_ack and burst_req both high is one beat. On the next cycle beat_valid is high and beat_data holds the oldest buffered word. At no other time is beat_valid high.
- R5: The fourth beat of a burst deasserts burst_req on the following cycle.
- R6: Each beat advances rd_ptr by 4 (32-bit) or 2 (16-bit), modulo 2^RING_AW. Each beat lowers rem_bytes by the same step, stopping at zero.
- R7: Prefetching stops once the loaded byte count is used up. No further burst is requested after the last full burst.
- R8: burst_ack while burst_req is low has no effect: no beat, and rd_ptr and rem_bytes stay unchanged.
- R9: A change on mode16 empties the prefetch buffer and drops burst_req on the next cycle. Fetching then restarts from rd_ptr in the new width.
- R10: load_en loads rd_ptr and rem_bytes from load_ptr and load_bytes, and discards any buffered words.
- R11: Across consecutive bursts, and across a width change, beats return consecutive ring addresses with no word skipped or repeated.
- R12: After reset, burst_req and beat_valid are low and rd_ptr and rem_bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode16 | input | 1 | 1 selects a 16-bit host, 0 selects 32-bit |
| load_en | input | 1 | Load the read pointer and byte count |
| load_ptr | input | RING_AW (8) | Starting byte pointer, aligned to the host width |
| load_bytes | input | CNT_W (12) | Number of bytes to read |
| fill_we | input | 1 | Ring RAM write strobe |
| fill_addr | input | RING_AW-2 (6) | Ring RAM word address |
| fill_data | input | 32 | Ring RAM write word |
| burst_ack | input | 1 | Host acknowledge, one beat per cycle |
| burst_req | output | 1 | Four host-width words ready for a burst |
| beat_valid | output | 1 | beat_data carries a delivered beat |
| beat_data | output | 32 | Delivered host word, byte lanes by mode |
| rd_ptr | output | RING_AW (8) | Byte pointer of the next word to deliver |
| rem_bytes | output | CNT_W (12) | Bytes not yet delivered |

## Verification
Some rules are checked by the bound assertions on every cycle: a request only rises with four words buffered, a beat only follows an acknowledged request, the pointer steps by one host width per beat and holds still otherwise, the request drops after the fourth beat and after a width change, and the buffer never overfills. Other behaviour only shows up in the bench's scenarios. That covers the byte-lane contents in each mode, wraparound at the end of the ring, the stop after a partial final group, and gap-free data across a width switch and a reload. Those checks depend on knowing the data preloaded into the ring.

// File: rtl/rxbp_pkg.sv
package rxbp_pkg;

  // Bytes consumed per host-width word.
  function automatic logic [2:0] step_of(input logic m16);
    return m16 ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/rxbp_ram.sv
module rxbp_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxbp_fetch.sv
module rxbp_fetch
  import rxbp_pkg::*;
#(
  parameter int RING_AW = 8,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode16,
  input  logic               restart,
  input  logic [RING_AW-1:0] start_ptr,
  input  logic [CNT_W-1:0]   start_bytes,
  input  logic               room_ok,
  input  logic [31:0]        ram_rdata,
  output logic [RING_AW-3:0] ram_raddr,
  output logic               pend,
  output logic               push,
  output logic [31:0]        push_data
);
  logic [RING_AW-1:0] fptr;
  logic [CNT_W-1:0]   fleft;
  logic               half_q;
  logic               issue;
  logic [2:0]         step;

  assign step      = step_of(mode16);
  assign issue     = !restart && (fleft != '0) && room_ok;
  assign ram_raddr = fptr[RING_AW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      fptr   <= '0;
      fleft  <= '0;
      pend   <= 1'b0;
      half_q <= 1'b0;
    end else if (restart) begin
      fptr   <= start_ptr;
      fleft  <= start_bytes;
      pend   <= 1'b0;
    end else begin
      pend <= issue;
      if (issue) begin
        half_q <= fptr[1];
        fptr   <= fptr + RING_AW'(step);
        fleft  <= (fleft > CNT_W'(step)) ? fleft - CNT_W'(step) : '0;
      end
    end
  end

  // A read in flight when a restart lands is dropped.
  assign push = pend && !restart;

  always_comb begin
    if (mode16)
      push_data = {16'h0000, half_q ? ram_rdata[31:16] : ram_rdata[15:0]};
    else
      push_data = ram_rdata;
  end
endmodule

// File: rtl/rxbp_fifo.sv
module rxbp_fifo #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [31:0]      wdata,
  input  logic             pop,
  output logic [31:0]      head,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wp;
  logic [PTR_W-1:0] rp;

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/rxbp_burst.sv
module rxbp_burst
  import rxbp_pkg::*;
#(
  parameter int RING_AW   = 8,
  parameter int CNT_W     = 12,
  parameter int BURST_LEN = 4,
  parameter int FCNT_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode16,
  input  logic               restart,
  input  logic               load_en,
  input  logic [RING_AW-1:0] load_ptr,
  input  logic [CNT_W-1:0]   load_bytes,
  input  logic               ack,
  input  logic [FCNT_W-1:0]  fifo_cnt,
  input  logic [31:0]        head,
  output logic               pop,
  output logic               req,
  output logic [$clog2(BURST_LEN)-1:0] idx,
  output logic               beat_valid,
  output logic [31:0]        beat_data,
  output logic [RING_AW-1:0] hptr,
  output logic [CNT_W-1:0]   hcnt
);
  localparam int IDX_W = $clog2(BURST_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BURST_LEN - 1);

  logic [2:0] step;

  assign step = step_of(mode16);
  assign pop  = ack && req && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      req        <= 1'b0;
      idx        <= '0;
      beat_valid <= 1'b0;
      beat_data  <= '0;
      hptr       <= '0;
      hcnt       <= '0;
    end else if (restart) begin
      req        <= 1'b0;
      idx        <= '0;
      beat_valid <= 1'b0;
      if (load_en) begin
        hptr <= load_ptr;
        hcnt <= load_bytes;
      end
    end else begin
      beat_valid <= pop;
      if (pop) begin
        beat_data <= head;
        hptr      <= hptr + RING_AW'(step);
        hcnt      <= (hcnt > CNT_W'(step)) ? hcnt - CNT_W'(step) : '0;
        idx       <= (idx == LAST) ? '0 : idx + 1'b1;
        if (idx == LAST) req <= 1'b0;
      end else if (!req && fifo_cnt >= FCNT_W'(BURST_LEN)) begin
        req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_burst_port.sv
module rx_burst_port #(
  parameter int RING_AW    = 8,
  parameter int CNT_W      = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int BURST_LEN  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode16,
  input  logic               load_en,
  input  logic [RING_AW-1:0] load_ptr,
  input  logic [CNT_W-1:0]   load_bytes,
  input  logic               fill_we,
  input  logic [RING_AW-3:0] fill_addr,
  input  logic [31:0]        fill_data,
  input  logic               burst_ack,
  output logic               burst_req,
  output logic               beat_valid,
  output logic [31:0]        beat_data,
  output logic [RING_AW-1:0] rd_ptr,
  output logic [CNT_W-1:0]   rem_bytes
);
  localparam int WORD_AW = RING_AW - 2;
  localparam int FCNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W   = $clog2(BURST_LEN);

  logic               mode_q;
  logic               mode_chg;
  logic               restart;
  logic [RING_AW-1:0] start_ptr;
  logic [CNT_W-1:0]   start_bytes;
  logic [WORD_AW-1:0] ram_raddr;
  logic [31:0]        ram_rdata;
  logic               pend;
  logic               push;
  logic [31:0]        push_data;
  logic               pop;
  logic [31:0]        head;
  logic [FCNT_W-1:0]  fifo_cnt;
  logic               room_ok;
  logic [IDX_W-1:0]   burst_idx;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= mode16;
  end

  assign mode_chg    = (mode16 != mode_q);
  assign restart     = load_en || mode_chg;
  assign start_ptr   = load_en ? load_ptr   : rd_ptr;
  assign start_bytes = load_en ? load_bytes : rem_bytes;
  assign room_ok     = ({1'b0, fifo_cnt} + {{FCNT_W{1'b0}}, pend})
                       < (FCNT_W + 1)'(FIFO_DEPTH);

  rxbp_ram #(.ADDR_W(WORD_AW), .DATA_W(32)) ram_i (
    .clk   (clk),
    .we    (fill_we),
    .waddr (fill_addr),
    .wdata (fill_data),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  rxbp_fetch #(.RING_AW(RING_AW), .CNT_W(CNT_W)) fetch_i (
    .clk         (clk),
    .rst         (rst),
    .mode16      (mode_q),
    .restart     (restart),
    .start_ptr   (start_ptr),
    .start_bytes (start_bytes),
    .room_ok     (room_ok),
    .ram_rdata   (ram_rdata),
    .ram_raddr   (ram_raddr),
    .pend        (pend),
    .push        (push),
    .push_data   (push_data)
  );

  rxbp_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(FCNT_W)) fifo_i (
    .clk   (clk),
    .rst   (rst),
    .flush (restart),
    .push  (push),
    .wdata (push_data),
    .pop   (pop),
    .head  (head),
    .count (fifo_cnt)
  );

  rxbp_burst #(
    .RING_AW(RING_AW), .CNT_W(CNT_W),
    .BURST_LEN(BURST_LEN), .FCNT_W(FCNT_W)
  ) burst_i (
    .clk        (clk),
    .rst        (rst),
    .mode16     (mode_q),
    .restart    (restart),
    .load_en    (load_en),
    .load_ptr   (load_ptr),
    .load_bytes (load_bytes),
    .ack        (burst_ack),
    .fifo_cnt   (fifo_cnt),
    .head       (head),
    .pop        (pop),
    .req        (burst_req),
    .idx        (burst_idx),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .hptr       (rd_ptr),
    .hcnt       (rem_bytes)
  );
endmodule

// File: rtl/rx_burst_port_chk.sv
module rx_burst_port_chk #(
  parameter int RING_AW    = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int BURST_LEN  = 4,
  parameter int FCNT_W     = 4,
  parameter int IDX_W      = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               mode16,
  input logic               mode_q,
  input logic               load_en,
  input logic               burst_ack,
  input logic               burst_req,
  input logic               beat_valid,
  input logic [RING_AW-1:0] rd_ptr,
  input logic [FCNT_W-1:0]  fifo_cnt,
  input logic [IDX_W-1:0]   burst_idx
);
  localparam logic [RING_AW-1:0] STEP2 = RING_AW'(2);
  localparam logic [RING_AW-1:0] STEP4 = RING_AW'(4);

  assert_req_needs_words_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_req) |-> ($past(fifo_cnt) >= FCNT_W'(BURST_LEN)));

  assert_beat_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> $past(burst_ack && burst_req));

  assert_req_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (burst_req && burst_ack && burst_idx == IDX_W'(BURST_LEN - 1)) |=> !burst_req);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (rd_ptr == $past(rd_ptr) + ($past(mode_q) ? STEP2 : STEP4)));

  assert_ptr_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!beat_valid && !$past(load_en)) |-> $stable(rd_ptr));

  assert_mode_flush_R9: assert property (@(posedge clk) disable iff (rst)
    (mode16 != $past(mode16)) |=> !burst_req);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= FCNT_W'(FIFO_DEPTH));
endmodule

bind rx_burst_port rx_burst_port_chk #(
  .RING_AW(RING_AW), .FIFO_DEPTH(FIFO_DEPTH), .BURST_LEN(BURST_LEN),
  .FCNT_W(FCNT_W), .IDX_W(IDX_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .mode16     (mode16),
  .mode_q     (mode_q),
  .load_en    (load_en),
  .burst_ack  (burst_ack),
  .burst_req  (burst_req),
  .beat_valid (beat_valid),
  .rd_ptr     (rd_ptr),
  .fifo_cnt   (fifo_cnt),
  .burst_idx  (burst_idx)
);

// File: tb/rx_burst_port_tb_top.sv
module rx_burst_port_tb_top;
  localparam int AW = 8;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode16 = 1'b0;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_ptr = '0;
  logic [CW-1:0] load_bytes = '0;
  logic          fill_we = 1'b0;
  logic [AW-3:0] fill_addr = '0;
  logic [31:0]   fill_data = '0;
  logic          burst_ack = 1'b0;
  logic          burst_req;
  logic          beat_valid;
  logic [31:0]   beat_data;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] rem_bytes;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  rx_burst_port dut_i (
    .clk(clk), .rst(rst), .mode16(mode16), .load_en(load_en),
    .load_ptr(load_ptr), .load_bytes(load_bytes), .fill_we(fill_we),
    .fill_addr(fill_addr), .fill_data(fill_data), .burst_ack(burst_ack),
    .burst_req(burst_req), .beat_valid(beat_valid), .beat_data(beat_data),
    .rd_ptr(rd_ptr), .rem_bytes(rem_bytes)
  );

  typedef struct packed {
    logic          m16;
    logic [AW-1:0] ptr;
    logic [CW-1:0] bytes;
    logic [AW-1:0] end_ptr;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 12'd32, 8'h20},
    '{1'b1, 8'h40, 12'd16, 8'h50},
    '{1'b0, 8'hF8, 12'd16, 8'h08},
    '{1'b1, 8'hFC, 12'd8,  8'h04}
  };

  function automatic logic [7:0] bv(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_beat(input logic m16, input logic [7:0] a);
    if (m16) return {16'h0000, bv(a + 8'd1), bv(a)};
    return {bv(a + 8'd3), bv(a + 8'd2), bv(a + 8'd1), bv(a)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [AW-1:0] p, input logic [CW-1:0] b);
    load_en = 1'b1; load_ptr = p; load_bytes = b;
    tick(1);
    load_en = 1'b0;
  endtask

  task automatic wait_req;
    int n = 0;
    while (!burst_req && n < 200) begin
      tick(1);
      n++;
    end
    check(burst_req, "R3", "burst_req after four words", 32'(burst_req), 32'd1);
  endtask

  // Four acknowledged beats starting at byte address a, host width from m16.
  task automatic do_burst(input logic m16, input logic [7:0] a);
    logic [7:0] addr = a;
    for (int k = 0; k < 4; k++) begin
      burst_ack = 1'b1;
      tick(1);
      if (k == 3) burst_ack = 1'b0;
      check(beat_valid == 1'b1, "R4", "beat_valid", 32'(beat_valid), 32'd1);
      check(beat_data == exp_beat(m16, addr), m16 ? "R2" : "R1",
            "beat_data lanes", beat_data, exp_beat(m16, addr));
      addr = addr + (m16 ? 8'd2 : 8'd4);
    end
    check(burst_req == 1'b0, "R5", "burst_req after fourth beat", 32'(burst_req), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    // Ring image: byte address a holds a ^ 0x5A, little-endian in each word.
    for (int w = 0; w < 64; w++) begin
      fill_we = 1'b1;
      fill_addr = 6'(w);
      fill_data = {bv(8'(4*w+3)), bv(8'(4*w+2)), bv(8'(4*w+1)), bv(8'(4*w))};
      tick(1);
    end
    fill_we = 1'b0;
    rst = 1'b0;
    tick(1);

    // R12 reset state
    check(burst_req == 1'b0, "R12", "burst_req", 32'(burst_req), 32'd0);
    check(beat_valid == 1'b0, "R12", "beat_valid", 32'(beat_valid), 32'd0);
    check(rd_ptr == '0, "R12", "rd_ptr", 32'(rd_ptr), 32'd0);
    check(rem_bytes == '0, "R12", "rem_bytes", 32'(rem_bytes), 32'd0);

    // Vector table: R1 R2 R6 R7 R10 R11, wrap cases included
    for (int v = 0; v < NV; v++) begin
      logic [7:0] a;
      int nb;
      mode16 = VECS[v].m16;
      tick(2);
      do_load(VECS[v].ptr, VECS[v].bytes);
      a  = VECS[v].ptr;
      nb = int'(VECS[v].bytes) / (VECS[v].m16 ? 8 : 16);
      for (int b = 0; b < nb; b++) begin
        wait_req();
        do_burst(VECS[v].m16, a);
        a = a + (VECS[v].m16 ? 8'd8 : 8'd16);
      end
      tick(6);
      check(burst_req == 1'b0, "R7", "no request after count used", 32'(burst_req), 32'd0);
      check(rd_ptr == VECS[v].end_ptr, "R6", "rd_ptr end", 32'(rd_ptr), 32'(VECS[v].end_ptr));
      check(rem_bytes == '0, "R6", "rem_bytes end", 32'(rem_bytes), 32'd0);
    end

    // R3 partial group: 6 words, one burst then two left over
    mode16 = 1'b0;
    tick(2);
    do_load(8'h80, 12'd24);
    check(rd_ptr == 8'h80, "R10", "rd_ptr loaded", 32'(rd_ptr), 32'h80);
    check(rem_bytes == 12'd24, "R10", "rem_bytes loaded", 32'(rem_bytes), 32'd24);
    wait_req();
    do_burst(1'b0, 8'h80);
    tick(10);
    check(burst_req == 1'b0, "R3", "two words only", 32'(burst_req), 32'd0);
    // R8 stray acknowledge
    burst_ack = 1'b1;
    tick(1);
    burst_ack = 1'b0;
    check(beat_valid == 1'b0, "R8", "no beat", 32'(beat_valid), 32'd0);
    tick(1);
    check(rd_ptr == 8'h90, "R8", "rd_ptr unchanged", 32'(rd_ptr), 32'h90);
    check(rem_bytes == 12'd8, "R8", "rem_bytes unchanged", 32'(rem_bytes), 32'd8);

    // R9 width change after one burst: continue from 0x10 as halfwords
    do_load(8'h00, 12'd64);
    wait_req();
    do_burst(1'b0, 8'h00);
    tick(3);
    mode16 = 1'b1;
    tick(1);
    check(burst_req == 1'b0, "R9", "request cleared on width change", 32'(burst_req), 32'd0);
    check(rd_ptr == 8'h10, "R9", "rd_ptr kept", 32'(rd_ptr), 32'h10);
    wait_req();
    do_burst(1'b1, 8'h10);
    check(rd_ptr == 8'h18, "R11", "rd_ptr after switch", 32'(rd_ptr), 32'h18);
    check(rem_bytes == 12'd40, "R6", "rem_bytes after switch", 32'(rem_bytes), 32'd40);

    // R10 reload mid-stream discards buffered words
    tick(2);
    do_load(8'hA0, 12'd8);
    wait_req();
    do_burst(1'b1, 8'hA0);
    check(rd_ptr == 8'hA8, "R10", "rd_ptr after reload", 32'(rd_ptr), 32'hA8);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule